// File: doc/BRIEF.md
# Private Cache Line Coherence Controller

This block tracks the MESI coherence state of a small set of lines in a processor's innermost private cache. It sits between the CPU request stream and the next-level private cache. It turns each CPU access (load, instruction fetch, store, replacement) and each message from the next level into a state change on the addressed line. It also drives outgoing request and response messages, a completion pulse back to the CPU, and an optional eviction notice. Data storage, tag lookup and victim choice are outside the block: the CPU side presents a line index, and the block keeps only a state and a dirty bit per line.

The block handles one event per cycle. A message from the next level always wins over a CPU request in the same cycle. A CPU request to a line that is waiting for a fill is refused (`cpuReady` low) until the line reaches a stable state. Outgoing requests and responses each pass through their own delay line, and each delay is a parameter.

Top module: `mesi_line_coherence`

## Requirements
- R1: After reset every line is invalid and no output pulse is active. A first load to any line therefore issues a read request.
- R2: In the invalid state, a load issues a read request (reqKind 0) and an instruction fetch also issues a read request (reqKind 0); both leave the line waiting for a fill. A store issues an exclusive request (reqKind 1) and leaves the line waiting for ownership.
- R3: A CPU request is refused (`cpuReady` low, nothing issued, line unchanged) while its line waits for a fill or for ownership, and in any cycle where `netValid` is high.
- R4: A line waiting for a read fill moves to shared on plain data (netKind 4) and to exclusive on exclusive data (netKind 5). Either fill raises `doneValid` with `doneMiss` high. Acks (netKind 6, 7) have no effect.
- R5: A line waiting for ownership completes only on exclusive data (netKind 5). It ends modified and dirty, with a `doneMiss` completion. Plain data leaves it waiting.
- R6: A load or fetch that hits in shared, exclusive or modified completes with `doneMiss` low and issues nothing. A store in exclusive or modified completes the same way and leaves the line modified and dirty.
- R7: A store to a shared line issues an upgrade request (reqKind 2) and leaves the line waiting for ownership.
- R8: An invalidate (netKind 0) to an invalid line or a waiting line answers with an ack (rspKind 0) and leaves the line waiting in the same way. In shared it also raises an eviction notice and drops the line.
- R9: An invalidate or a forwarded exclusive request (netKind 2, or forwarded upgrade netKind 8) drops an exclusive line with an ack only, and drops a modified line with a data response (rspKind 1) whose `rspDirty` is high. Both raise an eviction notice.
- R10: A forwarded read (netKind 1) or forwarded fetch (netKind 3) to an exclusive or modified line sends a data response (rspKind 1) carrying the dirty bit, clears it, and leaves the line shared.
- R11: Replacing (cpuOp 3) an exclusive or modified line issues a writeback (rspKind 2) with `rspDirty` equal to the dirty bit, meaning data is attached. Replacing a shared line drops it and sends nothing. All three raise an eviction notice. Replacing an invalid line has no effect.
- R12: Eviction notices appear only while `evictEn` is high. The line state changes the same way either way.
- R13: A request appears on the request port exactly REQ_DELAY cycles, and a response on the response port exactly RSP_DELAY cycles, after the cycle in which the event is presented. A completion appears one cycle after.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| evictEn | input | 1 | Enables eviction notices to the CPU |
| cpuValid | input | 1 | CPU request present |
| cpuOp | input | 2 | 0 load, 1 fetch, 2 store, 3 replace |
| cpuLine | input | LINE_W | Line index of the CPU request |
| cpuReady | output | 1 | CPU request consumed this cycle |
| netValid | input | 1 | Message from next level present |
| netKind | input | 4 | Message class (see requirements) |
| netLine | input | LINE_W | Line index of the message |
| reqValid | output | 1 | Outgoing request pulse |
| reqKind | output | 2 | 0 read, 1 exclusive, 2 upgrade |
| reqLine | output | LINE_W | Line of the request |
| rspValid | output | 1 | Outgoing response pulse |
| rspKind | output | 2 | 0 ack, 1 data, 2 writeback |
| rspDirty | output | 1 | Response carries dirty data |
| rspLine | output | LINE_W | Line of the response |
| doneValid | output | 1 | Access completion pulse |
| doneLine | output | LINE_W | Line that completed |
| doneMiss | output | 1 | Completion came from a fill |
| evictValid | output | 1 | Eviction notice pulse |
| evictLine | output | LINE_W | Line evicted |

## Verification
The bench builds the block with four lines, a request delay of 2 and a response delay of 3. The unequal delays make a message that leaves through the wrong path, or after the wrong delay, show up at the ports. With four lines, every start state can be reached and every CPU and network event can be applied to it, using a fresh reset for each case. After each event, the bench classifies the line state using only the ports: it sends a forwarded read, then checks `cpuReady`, then issues either a load or a data fill.

// File: rtl/mesi_line_pkg.sv
package mesi_line_pkg;

  typedef enum logic [2:0] {
    LS_I, LS_S, LS_E, LS_M, LS_IS, LS_IFS, LS_IM, LS_SM
  } lineState_t;

  typedef enum logic [1:0] {
    OP_LOAD, OP_IFETCH, OP_STORE, OP_REPL
  } cpuOp_t;

  localparam logic [3:0] NK_INV   = 4'd0;
  localparam logic [3:0] NK_FGETS = 4'd1;
  localparam logic [3:0] NK_FGETX = 4'd2;
  localparam logic [3:0] NK_FGETI = 4'd3;
  localparam logic [3:0] NK_DATA  = 4'd4;
  localparam logic [3:0] NK_DEXCL = 4'd5;
  localparam logic [3:0] NK_ACK   = 4'd6;
  localparam logic [3:0] NK_WBACK = 4'd7;
  localparam logic [3:0] NK_FUPG  = 4'd8;

  localparam logic [1:0] RQ_READ  = 2'd0;
  localparam logic [1:0] RQ_EXCL  = 2'd1;
  localparam logic [1:0] RQ_UPGR  = 2'd2;

  localparam logic [1:0] RS_ACK   = 2'd0;
  localparam logic [1:0] RS_DATA  = 2'd1;
  localparam logic [1:0] RS_WBACK = 2'd2;

  typedef struct packed {
    logic       wrState;
    lineState_t nextState;
    logic       setDirty;
    logic       clrDirty;
    logic       reqFire;
    logic [1:0] reqKind;
    logic       rspFire;
    logic [1:0] rspKind;
    logic       rspDirty;
    logic       doneFire;
    logic       doneMiss;
    logic       evictFire;
  } ctlStrobe_t;

  function automatic logic isTransient(lineState_t st);
    return (st == LS_IS) || (st == LS_IFS) || (st == LS_IM) || (st == LS_SM);
  endfunction

endpackage

// File: rtl/mesi_msg_delay.sv
module mesi_msg_delay #(
  parameter int DEPTH = 2,
  parameter int W     = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         inVld,
  input  logic [W-1:0] inDat,
  output logic         outVld,
  output logic [W-1:0] outDat
);
  logic [DEPTH-1:0]        vld;
  logic [DEPTH-1:0][W-1:0] dat;

  generate
    if (DEPTH == 1) begin : g_one
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          vld <= '0;
          dat <= '0;
        end else begin
          vld <= inVld;
          dat <= inDat;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          vld <= '0;
          dat <= '0;
        end else begin
          vld <= {vld[DEPTH-2:0], inVld};
          dat <= {dat[DEPTH-2:0], inDat};
        end
      end
    end
  endgenerate

  assign outVld = vld[DEPTH-1];
  assign outDat = dat[DEPTH-1];
endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
  import mesi_line_pkg::*;
#(
  parameter int LINE_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuValid,
  input  cpuOp_t            cpuOp,
  input  logic [LINE_W-1:0] cpuLine,
  input  logic              netValid,
  input  logic [3:0]        netKind,
  input  logic [LINE_W-1:0] netLine,
  input  lineState_t        selState,
  input  logic              selDirty,
  output logic [LINE_W-1:0] selLine,
  output logic              cpuReady,
  output ctlStrobe_t        strobe
);
  assign selLine  = netValid ? netLine : cpuLine;
  assign cpuReady = !netValid && !isTransient(selState);

  always_comb begin
    strobe           = '0;
    strobe.nextState = selState;
    if (netValid) begin
      unique case (netKind)
        NK_INV: begin
          strobe.rspFire = 1'b1;
          strobe.rspKind = RS_ACK;
          unique case (selState)
            LS_SM: begin
              strobe.wrState   = 1'b1;
              strobe.nextState = LS_IM;
            end
            LS_S, LS_E: begin
              strobe.wrState   = 1'b1;
              strobe.nextState = LS_I;
              strobe.clrDirty  = 1'b1;
              strobe.evictFire = 1'b1;
            end
            LS_M: begin
              strobe.rspKind   = RS_DATA;
              strobe.rspDirty  = selDirty;
              strobe.wrState   = 1'b1;
              strobe.nextState = LS_I;
              strobe.clrDirty  = 1'b1;
              strobe.evictFire = 1'b1;
            end
            default: ;
          endcase
        end
        NK_FGETX, NK_FUPG: begin
          if (selState == LS_E || selState == LS_M) begin
            strobe.rspFire   = 1'b1;
            strobe.rspKind   = (selState == LS_M) ? RS_DATA : RS_ACK;
            strobe.rspDirty  = (selState == LS_M) && selDirty;
            strobe.wrState   = 1'b1;
            strobe.nextState = LS_I;
            strobe.clrDirty  = 1'b1;
            strobe.evictFire = 1'b1;
          end
        end
        NK_FGETS, NK_FGETI: begin
          if (selState == LS_E || selState == LS_M) begin
            strobe.rspFire   = 1'b1;
            strobe.rspKind   = RS_DATA;
            strobe.rspDirty  = selDirty;
            strobe.wrState   = 1'b1;
            strobe.nextState = LS_S;
            strobe.clrDirty  = 1'b1;
          end
        end
        NK_DATA: begin
          if (selState == LS_IS || selState == LS_IFS) begin
            strobe.wrState   = 1'b1;
            strobe.nextState = LS_S;
            strobe.doneFire  = 1'b1;
            strobe.doneMiss  = 1'b1;
          end
        end
        NK_DEXCL: begin
          if (selState == LS_IS || selState == LS_IFS) begin
            strobe.wrState   = 1'b1;
            strobe.nextState = LS_E;
            strobe.doneFire  = 1'b1;
            strobe.doneMiss  = 1'b1;
          end else if (selState == LS_IM || selState == LS_SM) begin
            strobe.wrState   = 1'b1;
            strobe.nextState = LS_M;
            strobe.setDirty  = 1'b1;
            strobe.doneFire  = 1'b1;
            strobe.doneMiss  = 1'b1;
          end
        end
        default: ;
      endcase
    end else if (cpuValid && cpuReady) begin
      unique case (cpuOp)
        OP_LOAD, OP_IFETCH: begin
          if (selState == LS_I) begin
            strobe.reqFire   = 1'b1;
            strobe.reqKind   = RQ_READ;
            strobe.wrState   = 1'b1;
            strobe.nextState = (cpuOp == OP_IFETCH) ? LS_IFS : LS_IS;
          end else begin
            strobe.doneFire  = 1'b1;
          end
        end
        OP_STORE: begin
          unique case (selState)
            LS_I: begin
              strobe.reqFire   = 1'b1;
              strobe.reqKind   = RQ_EXCL;
              strobe.wrState   = 1'b1;
              strobe.nextState = LS_IM;
            end
            LS_S: begin
              strobe.reqFire   = 1'b1;
              strobe.reqKind   = RQ_UPGR;
              strobe.wrState   = 1'b1;
              strobe.nextState = LS_SM;
            end
            default: begin
              strobe.wrState   = 1'b1;
              strobe.nextState = LS_M;
              strobe.setDirty  = 1'b1;
              strobe.doneFire  = 1'b1;
            end
          endcase
        end
        OP_REPL: begin
          if (selState != LS_I) begin
            strobe.wrState   = 1'b1;
            strobe.nextState = LS_I;
            strobe.clrDirty  = 1'b1;
            strobe.evictFire = 1'b1;
            if (selState != LS_S) begin
              strobe.rspFire  = 1'b1;
              strobe.rspKind  = RS_WBACK;
              strobe.rspDirty = selDirty;
            end
          end
        end
        default: ;
      endcase
    end
  end

  p_one_msg_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.reqFire && strobe.rspFire));
endmodule

// File: rtl/mesi_line_datapath.sv
module mesi_line_datapath
  import mesi_line_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int LINE_W    = 3,
  parameter int REQ_DELAY = 2,
  parameter int RSP_DELAY = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              evictEn,
  input  logic [LINE_W-1:0] selLine,
  input  ctlStrobe_t        strobe,
  output lineState_t        selState,
  output logic              selDirty,
  output logic              reqValid,
  output logic [1:0]        reqKind,
  output logic [LINE_W-1:0] reqLine,
  output logic              rspValid,
  output logic [1:0]        rspKind,
  output logic              rspDirty,
  output logic [LINE_W-1:0] rspLine,
  output logic              doneValid,
  output logic [LINE_W-1:0] doneLine,
  output logic              doneMiss,
  output logic              evictValid,
  output logic [LINE_W-1:0] evictLine
);
  localparam int REQ_W = 2 + LINE_W;
  localparam int RSP_W = 3 + LINE_W;

  lineState_t             lineState [NUM_LINES];
  logic [NUM_LINES-1:0]   lineDirty;

  assign selState = lineState[selLine];
  assign selDirty = lineDirty[selLine];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_LINES; i++) lineState[i] <= LS_I;
      lineDirty <= '0;
    end else if (strobe.wrState) begin
      lineState[selLine] <= strobe.nextState;
      if (strobe.setDirty)      lineDirty[selLine] <= 1'b1;
      else if (strobe.clrDirty) lineDirty[selLine] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doneValid  <= 1'b0;
      doneLine   <= '0;
      doneMiss   <= 1'b0;
      evictValid <= 1'b0;
      evictLine  <= '0;
    end else begin
      doneValid  <= strobe.doneFire;
      doneLine   <= selLine;
      doneMiss   <= strobe.doneMiss;
      evictValid <= strobe.evictFire && evictEn;
      evictLine  <= selLine;
    end
  end

  logic [REQ_W-1:0] reqOut;
  logic [RSP_W-1:0] rspOut;

  mesi_msg_delay #(.DEPTH(REQ_DELAY), .W(REQ_W)) u_reqDelay (
    .clk(clk), .rstN(rstN),
    .inVld(strobe.reqFire), .inDat({strobe.reqKind, selLine}),
    .outVld(reqValid), .outDat(reqOut)
  );

  mesi_msg_delay #(.DEPTH(RSP_DELAY), .W(RSP_W)) u_rspDelay (
    .clk(clk), .rstN(rstN),
    .inVld(strobe.rspFire), .inDat({strobe.rspKind, strobe.rspDirty, selLine}),
    .outVld(rspValid), .outDat(rspOut)
  );

  assign reqKind  = reqOut[REQ_W-1 -: 2];
  assign reqLine  = reqOut[LINE_W-1:0];
  assign rspKind  = rspOut[RSP_W-1 -: 2];
  assign rspDirty = rspOut[LINE_W];
  assign rspLine  = rspOut[LINE_W-1:0];

  generate
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_lineChk
      p_dirty_m_r5: assert property (@(posedge clk) disable iff (!rstN)
        lineDirty[g] |-> lineState[g] == LS_M);
    end
  endgenerate

  p_upgrade_s_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.reqFire && strobe.reqKind == RQ_UPGR) |-> selState == LS_S);

  p_fill_transient_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.doneFire && strobe.doneMiss) |-> isTransient(selState));

  p_hit_stable_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.doneFire && !strobe.doneMiss) |-> (!isTransient(selState) && selState != LS_I));

  p_evict_gate_r12: assert property (@(posedge clk) disable iff (!rstN)
    !evictEn |=> !evictValid);
endmodule

// File: rtl/mesi_line_coherence.sv
module mesi_line_coherence
  import mesi_line_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int REQ_DELAY = 2,
  parameter int RSP_DELAY = 2,
  localparam int LINE_W   = $clog2(NUM_LINES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              evictEn,
  input  logic              cpuValid,
  input  logic [1:0]        cpuOp,
  input  logic [LINE_W-1:0] cpuLine,
  output logic              cpuReady,
  input  logic              netValid,
  input  logic [3:0]        netKind,
  input  logic [LINE_W-1:0] netLine,
  output logic              reqValid,
  output logic [1:0]        reqKind,
  output logic [LINE_W-1:0] reqLine,
  output logic              rspValid,
  output logic [1:0]        rspKind,
  output logic              rspDirty,
  output logic [LINE_W-1:0] rspLine,
  output logic              doneValid,
  output logic [LINE_W-1:0] doneLine,
  output logic              doneMiss,
  output logic              evictValid,
  output logic [LINE_W-1:0] evictLine
);
  lineState_t        selState;
  logic              selDirty;
  logic [LINE_W-1:0] selLine;
  ctlStrobe_t        strobe;

  mesi_line_ctrl #(.LINE_W(LINE_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .cpuValid(cpuValid), .cpuOp(cpuOp_t'(cpuOp)), .cpuLine(cpuLine),
    .netValid(netValid), .netKind(netKind), .netLine(netLine),
    .selState(selState), .selDirty(selDirty),
    .selLine(selLine), .cpuReady(cpuReady), .strobe(strobe)
  );

  mesi_line_datapath #(
    .NUM_LINES(NUM_LINES), .LINE_W(LINE_W),
    .REQ_DELAY(REQ_DELAY), .RSP_DELAY(RSP_DELAY)
  ) u_dp (
    .clk(clk), .rstN(rstN), .evictEn(evictEn),
    .selLine(selLine), .strobe(strobe),
    .selState(selState), .selDirty(selDirty),
    .reqValid(reqValid), .reqKind(reqKind), .reqLine(reqLine),
    .rspValid(rspValid), .rspKind(rspKind), .rspDirty(rspDirty), .rspLine(rspLine),
    .doneValid(doneValid), .doneLine(doneLine), .doneMiss(doneMiss),
    .evictValid(evictValid), .evictLine(evictLine)
  );

  p_net_priority_r3: assert property (@(posedge clk) disable iff (!rstN)
    netValid |-> !cpuReady);
endmodule

// File: tb/sim_mesi_line_coherence.sv
module sim_mesi_line_coherence;
  localparam int CLK_PERIOD = 10;
  localparam int NL    = 4;
  localparam int REQ_D = 2;
  localparam int RSP_D = 3;
  localparam int LW    = 2;
  localparam int C_I = 0, C_S = 1, C_E = 2, C_M = 3, C_RD = 4, C_WR = 5;

  logic clk = 0, rstN = 0, evictEn = 1;
  logic cpuValid = 0, netValid = 0;
  logic [1:0] cpuOp = 0;
  logic [LW-1:0] cpuLine = 0, netLine = 0;
  logic [3:0] netKind = 0;
  logic cpuReady, reqValid, rspValid, rspDirty, doneValid, doneMiss, evictValid;
  logic [1:0] reqKind, rspKind;
  logic [LW-1:0] reqLine, rspLine, doneLine, evictLine;

  int nChk = 0, nErr = 0;
  int reqCnt, reqK, reqL, rspCnt, rspK, rspD, rspL, doneCnt, doneM, doneL, evCnt, evL;

  always #(CLK_PERIOD/2) clk = ~clk;

  mesi_line_coherence #(.NUM_LINES(NL), .REQ_DELAY(REQ_D), .RSP_DELAY(RSP_D)) u0 (
    .clk(clk), .rstN(rstN), .evictEn(evictEn),
    .cpuValid(cpuValid), .cpuOp(cpuOp), .cpuLine(cpuLine), .cpuReady(cpuReady),
    .netValid(netValid), .netKind(netKind), .netLine(netLine),
    .reqValid(reqValid), .reqKind(reqKind), .reqLine(reqLine),
    .rspValid(rspValid), .rspKind(rspKind), .rspDirty(rspDirty), .rspLine(rspLine),
    .doneValid(doneValid), .doneLine(doneLine), .doneMiss(doneMiss),
    .evictValid(evictValid), .evictLine(evictLine)
  );

  always @(negedge clk) begin
    if (reqValid)   begin reqCnt++;  reqK = int'(reqKind); reqL = int'(reqLine); end
    if (rspValid)   begin rspCnt++;  rspK = int'(rspKind); rspD = int'(rspDirty); rspL = int'(rspLine); end
    if (doneValid)  begin doneCnt++; doneM = int'(doneMiss); doneL = int'(doneLine); end
    if (evictValid) begin evCnt++;   evL = int'(evictLine); end
  end

  task automatic chk(input string tag, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clearMon();
    reqCnt = 0; rspCnt = 0; doneCnt = 0; evCnt = 0;
  endtask

  task automatic doReset();
    @(posedge clk); #1 rstN = 0; cpuValid = 0; netValid = 0;
    repeat (2) @(posedge clk);
    #1 rstN = 1;
  endtask

  task automatic cpuEvt(input int op, input int line, output int acc);
    @(posedge clk); #1 cpuValid = 1; cpuOp = op[1:0]; cpuLine = line[LW-1:0];
    @(negedge clk); acc = int'(cpuReady);
    @(posedge clk); #1 cpuValid = 0;
  endtask

  task automatic netEvt(input int kind, input int line);
    @(posedge clk); #1 netValid = 1; netKind = kind[3:0]; netLine = line[LW-1:0];
    @(posedge clk); #1 netValid = 0;
  endtask

  task automatic settle();
    repeat (6) @(posedge clk);
    #1;
  endtask

  task automatic setup(input int ss, input int line);
    int a;
    case (ss)
      1: begin cpuEvt(0, line, a); settle(); netEvt(4, line); end
      2: begin cpuEvt(0, line, a); settle(); netEvt(5, line); end
      3: begin cpuEvt(2, line, a); settle(); netEvt(5, line); end
      4: cpuEvt(0, line, a);
      5: cpuEvt(1, line, a);
      6: cpuEvt(2, line, a);
      7: begin cpuEvt(0, line, a); settle(); netEvt(4, line); settle(); cpuEvt(2, line, a); end
      default: ;
    endcase
    settle();
  endtask

  task automatic probe(input int line, output int cls);
    int a;
    clearMon();
    netEvt(1, line); settle();
    if (rspCnt == 1) cls = rspD ? C_M : C_E;
    else begin
      @(posedge clk); #1 cpuLine = line[LW-1:0]; cpuValid = 0;
      @(negedge clk); a = int'(cpuReady);
      clearMon();
      if (a == 1) begin cpuEvt(0, line, a); settle(); cls = (reqCnt > 0) ? C_I : C_S; end
      else begin netEvt(4, line); settle(); cls = (doneCnt > 0) ? C_RD : C_WR; end
    end
  endtask

  // Expected behaviour per class and event, taken from the requirement list.
  task automatic model(input int c, input int ev, output int eAcc, output int eReq,
                       output int eRsp, output int eRspD, output int eDone,
                       output int eMiss, output int eEv, output int eNext);
    eAcc = 1; eReq = -1; eRsp = -1; eRspD = 0; eDone = 0; eMiss = 0; eEv = 0; eNext = c;
    if (ev < 4) begin
      if (c == C_RD || c == C_WR) eAcc = 0;
      else case (ev)
        0, 1: if (c == C_I) begin eReq = 0; eNext = C_RD; end else eDone = 1;
        2: if (c == C_I) begin eReq = 1; eNext = C_WR; end
           else if (c == C_S) begin eReq = 2; eNext = C_WR; end
           else begin eDone = 1; eNext = C_M; end
        default: if (c != C_I) begin
          eEv = 1; eNext = C_I;
          if (c != C_S) begin eRsp = 2; eRspD = (c == C_M); end
        end
      endcase
    end else case (ev - 4)
      0: begin
        eRsp = 0;
        if (c == C_S || c == C_E) begin eEv = 1; eNext = C_I; end
        if (c == C_M) begin eRsp = 1; eRspD = 1; eEv = 1; eNext = C_I; end
      end
      2, 8: if (c == C_E || c == C_M) begin
        eRsp = (c == C_M); eRspD = (c == C_M); eEv = 1; eNext = C_I;
      end
      1, 3: if (c == C_E || c == C_M) begin eRsp = 1; eRspD = (c == C_M); eNext = C_S; end
      4: if (c == C_RD) begin eDone = 1; eMiss = 1; eNext = C_S; end
      5: if (c == C_RD) begin eDone = 1; eMiss = 1; eNext = C_E; end
         else if (c == C_WR) begin eDone = 1; eMiss = 1; eNext = C_M; end
      default: ;
    endcase
  endtask

  function automatic string tagOf(input int c, input int ev);
    if (ev < 4) begin
      if (c == C_RD || c == C_WR) return "R3";
      if (ev == 3) return "R11";
      if (c == C_I) return "R2";
      if (ev == 2 && c == C_S) return "R7";
      return "R6";
    end
    case (ev - 4)
      0: return (c == C_E || c == C_M) ? "R9" : "R8";
      2, 8: return "R9";
      1, 3: return "R10";
      4, 5: return (c == C_WR) ? "R5" : "R4";
      default: return "R4";
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    nErr++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", nChk, nErr);
    $finish;
  end

  initial begin
    int acc, cls, line, eAcc, eReq, eRsp, eRspD, eDone, eMiss, eEv, eNext;
    string t;
    doReset();
    // R1: reset state
    @(negedge clk);
    chk("R1 outputs idle", int'(reqValid | rspValid | doneValid | evictValid), 0);
    chk("R1 ready", int'(cpuReady), 1);
    for (int l = 0; l < NL; l++) begin
      clearMon(); cpuEvt(0, l, acc); settle();
      chk("R1 first load reads", reqCnt * 10 + reqK, 10);
    end

    // R13: exact delays
    doReset(); clearMon();
    cpuEvt(2, 2, acc);
    for (int i = 1; i <= 4; i++) begin
      @(negedge clk); chk("R13 request delay", int'(reqValid), int'(i == REQ_D)); @(posedge clk);
    end
    doReset(); setup(2, 1);
    netEvt(1, 1);
    for (int i = 1; i <= 4; i++) begin
      @(negedge clk); chk("R13 response delay", int'(rspValid), int'(i == RSP_D)); @(posedge clk);
    end
    doReset(); setup(2, 3);
    cpuEvt(0, 3, acc);
    for (int i = 1; i <= 3; i++) begin
      @(negedge clk); chk("R13 completion delay", int'(doneValid), int'(i == 1)); @(posedge clk);
    end

    // R3: network has priority over a CPU request
    doReset(); clearMon();
    @(posedge clk); #1 cpuValid = 1; cpuOp = 0; cpuLine = 0; netValid = 1; netKind = 6; netLine = 1;
    @(negedge clk); chk("R3 refused under net", int'(cpuReady), 0);
    @(posedge clk); #1 cpuValid = 0; netValid = 0;
    settle(); chk("R3 nothing issued", reqCnt, 0);

    // R12: eviction notice gated
    doReset(); setup(1, 3); evictEn = 0; clearMon();
    cpuEvt(3, 3, acc); settle();
    chk("R12 no notice", evCnt, 0);
    probe(3, cls); chk("R12 line dropped", cls, C_I);
    evictEn = 1;

    // Sweep: every start state against every event
    for (int ss = 0; ss < 8; ss++) begin
      for (int ev = 0; ev < 13; ev++) begin
        int c;
        line = (ss * 13 + ev) % NL;
        c = (ss < 4) ? ss : (ss < 6 ? C_RD : C_WR);
        t = tagOf(c, ev);
        doReset(); setup(ss, line);
        model(c, ev, eAcc, eReq, eRsp, eRspD, eDone, eMiss, eEv, eNext);
        clearMon();
        if (ev < 4) begin cpuEvt(ev, line, acc); chk({t, " accept"}, acc, eAcc); end
        else netEvt(ev - 4, line);
        settle();
        chk({t, " request count"}, reqCnt, int'(eReq >= 0));
        if (eReq >= 0 && reqCnt > 0) chk({t, " request kind/line"}, reqK * 8 + reqL, eReq * 8 + line);
        chk({t, " response count"}, rspCnt, int'(eRsp >= 0));
        if (eRsp >= 0 && rspCnt > 0)
          chk({t, " response kind/dirty/line"}, rspK * 16 + rspD * 8 + rspL, eRsp * 16 + eRspD * 8 + line);
        chk({t, " completion count"}, doneCnt, eDone);
        if (eDone > 0 && doneCnt > 0) chk({t, " completion miss/line"}, doneM * 8 + doneL, eMiss * 8 + line);
        chk({t, " eviction count"}, evCnt, eEv);
        if (eEv > 0 && evCnt > 0) chk({t, " eviction line"}, evL, line);
        probe(line, cls);
        chk({t, " resulting state"}, cls, eNext);
      end
    end

    $display("CHECKS %0d ERRORS %0d", nChk, nErr);
    $finish;
  end
endmodule